// File: doc/BRIEF.md
# Domain Ingress Residence Time Stamper

This block sits at the entry gateway of every time-synchronized domain that a deterministic flow crosses, except the first one. Each packet arrives with a metadata descriptor. The descriptor holds the send time stamped by the previous domain's exit gateway and a running total of the delay so far. The exit gateway does no arithmetic. It only writes its send time, so the subtraction, the optional rate correction and the update of the running total all happen here.

The block takes the receive time from an input that was sampled when the frame arrived, not when the descriptor is processed. It subtracts the upstream send time modulo the counter width to get the residence time of the previous domain. Optionally it scales that value by a per-flow Q1.15 ratio that compensates for the offset between the two domains' clock frequencies. It adds the result to the running total and writes out both the new total and its own receive time, so the next domain can repeat the step.

A mode input selects where the correction settings come from: the fields carried in the descriptor, or a small per-flow table indexed by the flow number. The table can be rewritten at run time. A second mode input turns the block into the first domain's entry point, which only stamps its receive time and clears the total.

Descriptors move on a valid/ready stream. A descriptor transfers when valid and ready are both high at a rising edge. While `out_valid` is high and `out_ready` is low, the output fields hold. The three pipeline stages close any bubbles, so `in_ready` falls only when all three stages are full and the output is stalled.

Top module: `jrs_ingress_stamper`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: With correction off, the residence time is `in_rx_ts - in_send_ts` modulo 2^TS_W, and `out_acc_dly` equals `in_acc_dly` plus that residence time.
- R3: `out_rx_ts` equals the `in_rx_ts` of the same descriptor in every mode, and `out_flow` equals its `in_flow`.
- R4: With correction on, the residence time d is replaced by floor((d*ratio + 2^14) / 2^15) before it is added, where ratio is an unsigned 16-bit value with 15 fraction bits (0x8000 = 1.0). Halves round up.
- R5: When `cfg_src_table` is 1, the ratio and correction enable come from table entry `in_flow`, and the descriptor's `in_ratio` and `in_cor_en` are ignored. When it is 0, the descriptor fields are used.
- R6: A table write (`cfg_wr_en`, `cfg_wr_idx`, `cfg_wr_ratio`, `cfg_wr_cor_en`) at one rising edge applies to every descriptor accepted at a later edge.
- R7: When bit TS_W-1 of the modulo difference is 1 (the send time is later than the receive time), `out_bad` is 1 and `out_acc_dly` equals `in_acc_dly` unchanged. This means a difference of 2^(TS_W-1)-1 is still valid and 2^(TS_W-1) is invalid.
- R8: When `cfg_head` is 1 at acceptance, `out_acc_dly` is 0 and `out_bad` is 0, whatever the timestamps are.
- R9: If the sum exceeds 2^DLY_W-1, `out_acc_dly` saturates at 2^DLY_W-1. A sum that equals that value exactly is passed through unchanged.
- R10: The block accepts one descriptor per cycle. Its result is presented after the second rising edge following the accepting edge. Output fields hold while the output is stalled. `in_ready` is low only when the output is valid and stalled. Order is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_head | input | 1 | First-domain mode: stamp only and clear the total |
| cfg_src_table | input | 1 | 1 = correction settings from the table, 0 = from the descriptor |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_idx | input | FLOW_W | Table entry to write |
| cfg_wr_ratio | input | 16 | Q1.15 ratio to store |
| cfg_wr_cor_en | input | 1 | Correction enable to store |
| in_valid | input | 1 | Input descriptor valid |
| in_ready | output | 1 | Input descriptor accepted when high with `in_valid` |
| in_flow | input | FLOW_W | Flow index |
| in_send_ts | input | TS_W | Upstream exit send time |
| in_rx_ts | input | TS_W | Local receive time sampled at frame arrival |
| in_acc_dly | input | DLY_W | Running delay total |
| in_ratio | input | 16 | Descriptor-carried Q1.15 ratio |
| in_cor_en | input | 1 | Descriptor-carried correction enable |
| out_valid | output | 1 | Output descriptor valid |
| out_ready | input | 1 | Downstream can take the descriptor |
| out_flow | output | FLOW_W | Flow index |
| out_rx_ts | output | TS_W | New stamp: local receive time |
| out_acc_dly | output | DLY_W | Updated running delay total |
| out_bad | output | 1 | Upstream send time was later than the receive time |

## Verification
The bench builds the block with TS_W=16, DLY_W=20 and FLOW_N=4. A 16-bit counter lets directed timestamps reach the wrap-around point, as well as the exact edge where the difference crosses half the counter range. A 20-bit total brings both saturation and the exact-maximum case within reach using small residence values. Four flows are enough to hold different settings in neighbouring table entries and rewrite one of them between two descriptors.

// File: rtl/jrs_pkg.sv
package jrs_pkg;
  // Q1.15 rate-correction ratio
  localparam int RATIO_W = 16;
  localparam int FRAC_W  = 15;

  typedef enum logic {
    SRC_DESC  = 1'b0,
    SRC_TABLE = 1'b1
  } cfg_src_e;
endpackage

// File: rtl/jrs_cfg_table.sv
module jrs_cfg_table #(
  parameter int FLOW_N  = 16,
  parameter int FLOW_W  = 4,
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FLOW_W-1:0]  wr_idx,
  input  logic [RATIO_W-1:0] wr_ratio,
  input  logic               wr_cor_en,
  input  logic [FLOW_W-1:0]  rd_idx,
  output logic [RATIO_W-1:0] rd_ratio,
  output logic               rd_cor_en
);
  logic [RATIO_W-1:0] ratio_q [FLOW_N];
  logic               en_q    [FLOW_N];

  for (genvar g = 0; g < FLOW_N; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ratio_q[g] <= RATIO_W'(1) << (RATIO_W - 1);
        en_q[g]    <= 1'b0;
      end else if (wr_en && (32'(wr_idx) == g)) begin
        ratio_q[g] <= wr_ratio;
        en_q[g]    <= wr_cor_en;
      end
    end
  end

  always_comb begin
    rd_ratio  = '0;
    rd_cor_en = 1'b0;
    for (int i = 0; i < FLOW_N; i++) begin
      if (32'(rd_idx) == i) begin
        rd_ratio  = ratio_q[i];
        rd_cor_en = en_q[i];
      end
    end
  end
endmodule

// File: rtl/jrs_delta_stage.sv
module jrs_delta_stage #(
  parameter int TS_W    = 32,
  parameter int DLY_W   = 32,
  parameter int FLOW_W  = 4,
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               i_valid,
  output logic               i_ready,
  input  logic               head_mode,
  input  logic               use_table,
  input  logic [FLOW_W-1:0]  i_flow,
  input  logic [TS_W-1:0]    i_send_ts,
  input  logic [TS_W-1:0]    i_rx_ts,
  input  logic [DLY_W-1:0]   i_acc,
  input  logic [RATIO_W-1:0] desc_ratio,
  input  logic               desc_cor_en,
  input  logic [RATIO_W-1:0] tbl_ratio,
  input  logic               tbl_cor_en,
  output logic               o_valid,
  input  logic               o_ready,
  output logic [FLOW_W-1:0]  o_flow,
  output logic [TS_W-1:0]    o_rx_ts,
  output logic [TS_W-1:0]    o_diff,
  output logic [DLY_W-1:0]   o_acc,
  output logic [RATIO_W-1:0] o_ratio,
  output logic               o_cor_en,
  output logic               o_bad,
  output logic               o_head
);
  logic [TS_W-1:0]    diff;
  logic [RATIO_W-1:0] sel_ratio;
  logic               sel_en;

  always_comb begin
    diff      = i_rx_ts - i_send_ts;
    sel_ratio = use_table ? tbl_ratio  : desc_ratio;
    sel_en    = use_table ? tbl_cor_en : desc_cor_en;
  end

  assign i_ready = !o_valid || o_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid  <= 1'b0;
      o_flow   <= '0;
      o_rx_ts  <= '0;
      o_diff   <= '0;
      o_acc    <= '0;
      o_ratio  <= '0;
      o_cor_en <= 1'b0;
      o_bad    <= 1'b0;
      o_head   <= 1'b0;
    end else if (i_ready) begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_flow   <= i_flow;
        o_rx_ts  <= i_rx_ts;
        o_diff   <= diff;
        o_acc    <= i_acc;
        o_ratio  <= sel_ratio;
        o_cor_en <= sel_en;
        o_bad    <= diff[TS_W-1] && !head_mode;
        o_head   <= head_mode;
      end
    end
  end
endmodule

// File: rtl/jrs_scale_stage.sv
module jrs_scale_stage #(
  parameter int TS_W    = 32,
  parameter int DLY_W   = 32,
  parameter int FLOW_W  = 4,
  parameter int RATIO_W = 16,
  parameter int FRAC_W  = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               i_valid,
  output logic               i_ready,
  input  logic [FLOW_W-1:0]  i_flow,
  input  logic [TS_W-1:0]    i_rx_ts,
  input  logic [TS_W-1:0]    i_diff,
  input  logic [DLY_W-1:0]   i_acc,
  input  logic [RATIO_W-1:0] i_ratio,
  input  logic               i_cor_en,
  input  logic               i_bad,
  input  logic               i_head,
  output logic               o_valid,
  input  logic               o_ready,
  output logic [FLOW_W-1:0]  o_flow,
  output logic [TS_W-1:0]    o_rx_ts,
  output logic [TS_W:0]      o_scaled,
  output logic [DLY_W-1:0]   o_acc,
  output logic               o_bad,
  output logic               o_head
);
  localparam int PROD_W = TS_W + RATIO_W;
  localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);

  logic [PROD_W-1:0] prod;
  logic [TS_W:0]     scaled;
  logic              unused_lo;

  always_comb begin
    prod   = PROD_W'(i_diff) * PROD_W'(i_ratio) + HALF;
    scaled = i_cor_en ? prod[FRAC_W +: TS_W+1] : {1'b0, i_diff};
  end
  assign unused_lo = ^prod[FRAC_W-1:0];

  assign i_ready = !o_valid || o_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid  <= 1'b0;
      o_flow   <= '0;
      o_rx_ts  <= '0;
      o_scaled <= '0;
      o_acc    <= '0;
      o_bad    <= 1'b0;
      o_head   <= 1'b0;
    end else if (i_ready) begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_flow   <= i_flow;
        o_rx_ts  <= i_rx_ts;
        o_scaled <= scaled;
        o_acc    <= i_acc;
        o_bad    <= i_bad;
        o_head   <= i_head;
      end
    end
  end
endmodule

// File: rtl/jrs_accum_stage.sv
module jrs_accum_stage #(
  parameter int TS_W   = 32,
  parameter int DLY_W  = 32,
  parameter int FLOW_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  output logic              i_ready,
  input  logic [FLOW_W-1:0] i_flow,
  input  logic [TS_W-1:0]   i_rx_ts,
  input  logic [TS_W:0]     i_scaled,
  input  logic [DLY_W-1:0]  i_acc,
  input  logic              i_bad,
  input  logic              i_head,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [FLOW_W-1:0] o_flow,
  output logic [TS_W-1:0]   o_rx_ts,
  output logic [DLY_W-1:0]  o_acc,
  output logic              o_bad
);
  localparam int WIDE_W = (DLY_W > TS_W + 1) ? DLY_W : TS_W + 1;
  localparam int SUM_W  = WIDE_W + 1;
  localparam logic [SUM_W-1:0] DLY_MAX = SUM_W'({DLY_W{1'b1}});

  logic [SUM_W-1:0] sum;
  logic [DLY_W-1:0] next_acc;

  always_comb begin
    sum = SUM_W'(i_acc) + SUM_W'(i_scaled);
    if (i_head)
      next_acc = '0;
    else if (i_bad)
      next_acc = i_acc;
    else if (sum > DLY_MAX)
      next_acc = {DLY_W{1'b1}};
    else
      next_acc = sum[DLY_W-1:0];
  end

  assign i_ready = !o_valid || o_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_flow  <= '0;
      o_rx_ts <= '0;
      o_acc   <= '0;
      o_bad   <= 1'b0;
    end else if (i_ready) begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_flow  <= i_flow;
        o_rx_ts <= i_rx_ts;
        o_acc   <= next_acc;
        o_bad   <= i_bad;
      end
    end
  end
endmodule

// File: rtl/jrs_ingress_stamper.sv
module jrs_ingress_stamper #(
  parameter int TS_W   = 32,
  parameter int DLY_W  = 32,
  parameter int FLOW_N = 16,
  localparam int FLOW_W  = (FLOW_N > 1) ? $clog2(FLOW_N) : 1,
  localparam int RATIO_W = jrs_pkg::RATIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_head,
  input  logic               cfg_src_table,
  input  logic               cfg_wr_en,
  input  logic [FLOW_W-1:0]  cfg_wr_idx,
  input  logic [RATIO_W-1:0] cfg_wr_ratio,
  input  logic               cfg_wr_cor_en,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FLOW_W-1:0]  in_flow,
  input  logic [TS_W-1:0]    in_send_ts,
  input  logic [TS_W-1:0]    in_rx_ts,
  input  logic [DLY_W-1:0]   in_acc_dly,
  input  logic [RATIO_W-1:0] in_ratio,
  input  logic               in_cor_en,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FLOW_W-1:0]  out_flow,
  output logic [TS_W-1:0]    out_rx_ts,
  output logic [DLY_W-1:0]   out_acc_dly,
  output logic               out_bad
);
  jrs_pkg::cfg_src_e src_mode;
  logic              use_table;
  logic [RATIO_W-1:0] tbl_ratio;
  logic               tbl_cor_en;

  assign src_mode  = jrs_pkg::cfg_src_e'(cfg_src_table);
  assign use_table = (src_mode == jrs_pkg::SRC_TABLE);

  // stage 1 -> stage 2
  logic               s1_valid, s1_ready;
  logic [FLOW_W-1:0]  s1_flow;
  logic [TS_W-1:0]    s1_rx_ts, s1_diff;
  logic [DLY_W-1:0]   s1_acc;
  logic [RATIO_W-1:0] s1_ratio;
  logic               s1_cor_en, s1_bad, s1_head;

  // stage 2 -> stage 3
  logic               s2_valid, s2_ready;
  logic [FLOW_W-1:0]  s2_flow;
  logic [TS_W-1:0]    s2_rx_ts;
  logic [TS_W:0]      s2_scaled;
  logic [DLY_W-1:0]   s2_acc;
  logic               s2_bad, s2_head;

  jrs_cfg_table #(.FLOW_N(FLOW_N), .FLOW_W(FLOW_W), .RATIO_W(RATIO_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx), .wr_ratio(cfg_wr_ratio),
    .wr_cor_en(cfg_wr_cor_en),
    .rd_idx(in_flow), .rd_ratio(tbl_ratio), .rd_cor_en(tbl_cor_en)
  );

  jrs_delta_stage #(.TS_W(TS_W), .DLY_W(DLY_W), .FLOW_W(FLOW_W), .RATIO_W(RATIO_W)) u_delta (
    .clk(clk), .rst_n(rst_n),
    .i_valid(in_valid), .i_ready(in_ready),
    .head_mode(cfg_head), .use_table(use_table),
    .i_flow(in_flow), .i_send_ts(in_send_ts), .i_rx_ts(in_rx_ts), .i_acc(in_acc_dly),
    .desc_ratio(in_ratio), .desc_cor_en(in_cor_en),
    .tbl_ratio(tbl_ratio), .tbl_cor_en(tbl_cor_en),
    .o_valid(s1_valid), .o_ready(s1_ready),
    .o_flow(s1_flow), .o_rx_ts(s1_rx_ts), .o_diff(s1_diff), .o_acc(s1_acc),
    .o_ratio(s1_ratio), .o_cor_en(s1_cor_en), .o_bad(s1_bad), .o_head(s1_head)
  );

  jrs_scale_stage #(.TS_W(TS_W), .DLY_W(DLY_W), .FLOW_W(FLOW_W), .RATIO_W(RATIO_W),
                    .FRAC_W(jrs_pkg::FRAC_W)) u_scale (
    .clk(clk), .rst_n(rst_n),
    .i_valid(s1_valid), .i_ready(s1_ready),
    .i_flow(s1_flow), .i_rx_ts(s1_rx_ts), .i_diff(s1_diff), .i_acc(s1_acc),
    .i_ratio(s1_ratio), .i_cor_en(s1_cor_en), .i_bad(s1_bad), .i_head(s1_head),
    .o_valid(s2_valid), .o_ready(s2_ready),
    .o_flow(s2_flow), .o_rx_ts(s2_rx_ts), .o_scaled(s2_scaled), .o_acc(s2_acc),
    .o_bad(s2_bad), .o_head(s2_head)
  );

  jrs_accum_stage #(.TS_W(TS_W), .DLY_W(DLY_W), .FLOW_W(FLOW_W)) u_accum (
    .clk(clk), .rst_n(rst_n),
    .i_valid(s2_valid), .i_ready(s2_ready),
    .i_flow(s2_flow), .i_rx_ts(s2_rx_ts), .i_scaled(s2_scaled), .i_acc(s2_acc),
    .i_bad(s2_bad), .i_head(s2_head),
    .o_valid(out_valid), .o_ready(out_ready),
    .o_flow(out_flow), .o_rx_ts(out_rx_ts), .o_acc(out_acc_dly), .o_bad(out_bad)
  );
endmodule

// File: rtl/jrs_ingress_stamper_chk.sv
module jrs_ingress_stamper_chk #(
  parameter int TS_W   = 32,
  parameter int DLY_W  = 32,
  parameter int FLOW_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FLOW_W-1:0] out_flow,
  input logic [TS_W-1:0]   out_rx_ts,
  input logic [DLY_W-1:0]  out_acc_dly,
  input logic              out_bad,
  input logic              s2_valid,
  input logic              s2_bad,
  input logic              s2_head,
  input logic [DLY_W-1:0]  s2_acc
);
  logic out_take;
  assign out_take = !out_valid || out_ready;

  // R1
  rst_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R10
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_acc_dly) && $stable(out_rx_ts)
                                   && $stable(out_flow) && $stable(out_bad)));

  // R10
  ready_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R7
  bad_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_bad && !s2_head && out_take) |=> (out_bad && out_acc_dly == $past(s2_acc)));

  // R8
  head_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_head && out_take) |=> (!out_bad && out_acc_dly == '0));
endmodule

bind jrs_ingress_stamper jrs_ingress_stamper_chk #(
  .TS_W(TS_W), .DLY_W(DLY_W), .FLOW_W(FLOW_W)
) u_chk (.*);

// File: tb/jrs_ingress_stamper_bench.sv
module jrs_ingress_stamper_bench;
  localparam int TS_W = 16, DLY_W = 20, FLOW_N = 4, FLOW_W = 2;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic cfg_head = 0, cfg_src_table = 0, cfg_wr_en = 0, cfg_wr_cor_en = 0;
  logic [FLOW_W-1:0] cfg_wr_idx = '0;
  logic [15:0] cfg_wr_ratio = '0;
  logic in_valid = 0, in_cor_en = 0, out_ready = 1;
  logic in_ready, out_valid, out_bad;
  logic [FLOW_W-1:0] in_flow = '0, out_flow;
  logic [TS_W-1:0] in_send_ts = '0, in_rx_ts = '0, out_rx_ts;
  logic [DLY_W-1:0] in_acc_dly = '0, out_acc_dly;
  logic [15:0] in_ratio = '0;

  always #4 clk = ~clk;

  jrs_ingress_stamper #(.TS_W(TS_W), .DLY_W(DLY_W), .FLOW_N(FLOW_N)) u_jrs_ingress_stamper (
    .clk(clk), .rst_n(rst_n), .cfg_head(cfg_head), .cfg_src_table(cfg_src_table),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_ratio(cfg_wr_ratio),
    .cfg_wr_cor_en(cfg_wr_cor_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_flow(in_flow), .in_send_ts(in_send_ts), .in_rx_ts(in_rx_ts),
    .in_acc_dly(in_acc_dly), .in_ratio(in_ratio), .in_cor_en(in_cor_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_flow(out_flow),
    .out_rx_ts(out_rx_ts), .out_acc_dly(out_acc_dly), .out_bad(out_bad)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [15:0] tbl_ratio [FLOW_N];
  logic        tbl_en    [FLOW_N];

  logic [FLOW_W-1:0] e_flow [DEPTH];
  logic [TS_W-1:0]   e_rx   [DEPTH];
  logic [DLY_W-1:0]  e_acc  [DEPTH];
  logic              e_bad  [DEPTH];
  string             e_tag  [DEPTH];
  int acc_cyc [DEPTH];
  int got_cyc [DEPTH];
  int wr = 0, rd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // output monitor: compares each transfer with the bench's own expectation
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (rd >= wr) check(0, "R10", "unexpected output", rd, wr);
      else begin
        got_cyc[rd] = cyc;
        check(out_acc_dly == e_acc[rd], e_tag[rd], "acc_dly", out_acc_dly, e_acc[rd]);
        check(out_bad == e_bad[rd], e_tag[rd], "bad", out_bad, e_bad[rd]);
        check(out_rx_ts == e_rx[rd] && out_flow == e_flow[rd], "R3", "rx_ts/flow",
              {out_flow, out_rx_ts}, {e_flow[rd], e_rx[rd]});
        rd++;
      end
    end
  end

  task automatic send(input int flow, input int snd, input int rx, input int acc,
                      input int ratio, input bit cor, input string tag);
    logic [TS_W-1:0] d;
    longint sc, sum;
    bit en;
    int r;
    d   = TS_W'(rx - snd);
    en  = cfg_src_table ? tbl_en[flow] : cor;
    r   = cfg_src_table ? int'(tbl_ratio[flow]) : ratio;
    sc  = en ? ((longint'(d) * r + 16384) >>> 15) : longint'(d);
    sum = acc + sc;
    if (sum > (1 << DLY_W) - 1) sum = (1 << DLY_W) - 1;
    e_flow[wr] = FLOW_W'(flow);
    e_rx[wr]   = TS_W'(rx);
    e_bad[wr]  = d[TS_W-1] && !cfg_head;
    e_acc[wr]  = cfg_head ? '0 : (d[TS_W-1] ? DLY_W'(acc) : DLY_W'(sum));
    e_tag[wr]  = tag;
    @(negedge clk);
    in_flow = FLOW_W'(flow); in_send_ts = TS_W'(snd); in_rx_ts = TS_W'(rx);
    in_acc_dly = DLY_W'(acc); in_ratio = 16'(ratio); in_cor_en = cor; in_valid = 1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    acc_cyc[wr] = cyc;
    wr++;
    in_valid = 0;
  endtask

  task automatic drain();
    int w = 0;
    while (rd < wr && w < 50) begin @(negedge clk); w++; end
    check(rd == wr, "R10", "drain count", rd, wr);
  endtask

  task automatic tbl_write(input int idx, input int ratio, input bit en);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_idx = FLOW_W'(idx); cfg_wr_ratio = 16'(ratio); cfg_wr_cor_en = en;
    @(negedge clk);
    cfg_wr_en = 0;
    tbl_ratio[idx] = 16'(ratio); tbl_en[idx] = en;
  endtask

  task automatic set_ready(input bit v);
    @(posedge clk); #2 out_ready = v;
  endtask

  task automatic t_reset();
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_basic();
    send(0, 1000, 1250, 7, 16'h4000, 0, "R2");
    send(1, 65500, 30, 100, 0, 0, "R2");   // counter wrap: residence 66
    send(3, 5, 5, 12345, 0, 0, "R2");      // zero residence
    drain();
  endtask

  task automatic t_round();
    send(0, 0, 3, 0, 16'h4000, 1, "R4");     // 1.5 rounds to 2
    send(1, 0, 1, 0, 16'h4000, 1, "R4");     // 0.5 rounds to 1
    send(2, 0, 1000, 10, 16'h8148, 1, "R4");
    send(3, 0, 1000, 0, 16'h8000, 1, "R4");  // unity ratio
    drain();
  endtask

  task automatic t_table();
    tbl_write(2, 16'h4000, 1);
    tbl_write(1, 16'h4000, 0);
    cfg_src_table = 1;
    send(2, 0, 400, 0, 16'h8000, 0, "R5");   // table scales despite descriptor
    send(1, 0, 400, 0, 16'h2000, 1, "R5");   // table disables despite descriptor
    drain();
    cfg_src_table = 0;
    send(2, 0, 400, 0, 16'h8000, 0, "R5");   // descriptor fields again
    drain();
  endtask

  task automatic t_update();
    cfg_src_table = 1;
    tbl_write(3, 16'h8000, 1);
    send(3, 0, 800, 0, 0, 0, "R6");
    tbl_write(3, 16'h2000, 1);
    send(3, 0, 800, 0, 0, 0, "R6");
    drain();
    cfg_src_table = 0;
  endtask

  task automatic t_invalid();
    send(0, 200, 100, 4321, 0, 0, "R7");
    send(1, 0, 16'h7FFF, 0, 0, 0, "R7");     // largest valid difference
    send(2, 0, 16'h8000, 55, 0, 0, "R7");    // smallest invalid difference
    drain();
  endtask

  task automatic t_head();
    cfg_head = 1;
    send(1, 200, 100, 555, 0, 0, "R8");
    send(2, 10, 900, 77, 16'h4000, 1, "R8");
    drain();
    cfg_head = 0;
  endtask

  task automatic t_sat();
    send(0, 0, 16'h100, 20'hFFFF0, 0, 0, "R9");
    send(1, 0, 16'hFF, 20'hFFF00, 0, 0, "R9");  // exactly the maximum
    drain();
  endtask

  task automatic t_stall();
    logic [DLY_W-1:0] held;
    set_ready(0);
    send(0, 0, 10, 1, 0, 0, "R10");
    send(1, 0, 20, 2, 0, 0, "R10");
    send(2, 0, 30, 3, 0, 0, "R10");
    @(negedge clk);
    check(in_ready == 0, "R10", "in_ready with all stages full", in_ready, 0);
    held = out_acc_dly;
    repeat (3) @(negedge clk);
    check(out_valid == 1 && out_acc_dly == held, "R10", "held output", out_acc_dly, held);
    set_ready(1);
    drain();
  endtask

  task automatic t_latency();
    int first;
    first = wr;
    for (int i = 0; i < 4; i++) send(i, 0, 100 + i, i, 0, 0, "R10");
    drain();
    for (int i = first; i < first + 4; i++)
      check(got_cyc[i] - acc_cyc[i] == 2, "R10", "latency", got_cyc[i] - acc_cyc[i], 2);
    for (int i = first; i < first + 3; i++)
      check(acc_cyc[i+1] - acc_cyc[i] == 1, "R10", "accept spacing",
            acc_cyc[i+1] - acc_cyc[i], 1);
  endtask

  initial begin
    for (int i = 0; i < FLOW_N; i++) begin tbl_ratio[i] = 16'h8000; tbl_en[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_round();
    t_table();
    t_update();
    t_invalid();
    t_head();
    t_sat();
    t_stall();
    t_latency();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", rd, wr);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule